// File: doc/BRIEF.md
# Serial Control Register Slave for a Programmable-Gain Amplifier

This block receives one-byte control frames over a three-wire, write-only serial link (active-low select, serial clock, data in) and turns them into the static control words that steer an amplifier: an offset-trim sign and magnitude, a 4-bit gain code with a decoded gain index, a shutdown flag and an offset-measure flag. The serial clock is not used as a clock. All three serial lines are brought into the system clock domain through a synchronizer and their edges are found by sampling, so the system clock must run several times faster than the serial clock.

A frame is eight bits, least significant first, sampled on rising serial-clock edges while select is low (clock idles low). The byte takes effect only when select returns high after a complete byte. Its lowest bit steers the payload to the trim register or the gain register, while the top two bits rewrite the shutdown and measure flags on every accepted frame. There is no readback.

Top module: `pga_ctrl_spi`

## Requirements
- R1: After reset every output is zero: trim positive with magnitude 0, gain code 0000, shutdown 0, measure 0, and the gain index reads 1 (unity).
- R2: Bits are taken on rising serial-clock edges while select is low, least significant bit first, so the first bit sent lands in byte bit 0 and the eighth in byte bit 7.
- R3: Outputs change only on a rising edge of select that follows the falling edge of the eighth serial clock of the frame; a frame with fewer bits, or one closed while the eighth clock is still high, leaves every output unchanged.
- R4: When byte bit 0 is 0, trim sign takes bit 5 (1 means negative) and trim magnitude takes bits 4 to 1; gain code and gain index keep their values.
- R5: When byte bit 0 is 1, the gain code takes bits 4 to 1, bit 5 has no effect, and the trim sign and magnitude keep their values.
- R6: Every accepted frame writes shutdown from byte bit 7 and measure from byte bit 6, whichever register it targets.
- R7: The gain index is derived from the gain code: 1001 gives 0 (0.2), 0000 and 1010 give 1 (unity), 0001..1000 give 2..9 in rising gain order (10, 20, 30, 40, 60, 80, 120, 157).
- R8: Gain codes 1011 to 1111 are stored unchanged in the gain code output and give gain index 1.
- R9: Serial clock pulses after the eighth in a frame are ignored; the first eight bits are the ones committed.
- R10: Frames are accepted and decoded while shutdown is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data in |
| trimNeg | output | 1 | Trim polarity, 1 = negative |
| trimMag | output | 4 | Trim magnitude code |
| gainCode | output | 4 | Stored gain code |
| gainIdx | output | 4 | Decoded gain index |
| shutdown | output | 1 | Low-power shutdown request |
| measure | output | 1 | Offset-measure request |

## Verification
Every one of the 256 byte values is sent as a full frame in ascending order, so both select values, every trim and gain code including the reserved ones, both values of the ignored bit, and all flag pairs are seen, and each frame's effect is compared against a model that also tracks which register must stay put. Because shutdown frames sit in the upper half of the sweep, the later frames show decode staying alive in shutdown. Separate frames with seven bits, with select closed while the eighth clock is high, and with ten clocks tell a proper commit apart from a premature or overrun one.

// File: rtl/pga_spi_pkg.sv
package pga_spi_pkg;
  localparam int FRAME_BITS = 8;
  localparam int CODE_W     = 4;
  localparam int IDX_W      = 4;
  localparam logic [IDX_W-1:0] UNITY_IDX = IDX_W'(1);

  typedef struct packed {
    logic shiftEn;
    logic bitIn;
    logic commit;
  } spiStrobe_t;

  // Gain code -> index ordered by gain magnitude
  function automatic logic [IDX_W-1:0] gainIndex(input logic [CODE_W-1:0] code);
    logic [IDX_W-1:0] idx;
    if (code == CODE_W'(9))
      idx = '0;
    else if (code >= CODE_W'(1) && code <= CODE_W'(8))
      idx = IDX_W'(code) + IDX_W'(1);
    else
      idx = UNITY_IDX;
    return idx;
  endfunction
endpackage

// File: rtl/pga_spi_ctrl.sv
module pga_spi_ctrl
  import pga_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output spiStrobe_t stb
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, mosiPipe;
  logic csS, sclkS, mosiS, csPrev, sclkPrev;
  logic csFall, csRise, sclkRise, sclkFall;
  logic [CNT_W-1:0] bitCnt;
  logic fullByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      mosiPipe <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS   = csPipe[SYNC_STAGES-1];
  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign mosiS = mosiPipe[SYNC_STAGES-1];

  assign csFall   =  csPrev & ~csS;
  assign csRise   = ~csPrev &  csS;
  assign sclkRise = ~sclkPrev &  sclkS;
  assign sclkFall =  sclkPrev & ~sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      fullByte <= 1'b0;
    end else if (csFall) begin
      bitCnt   <= '0;
      fullByte <= 1'b0;
    end else if (!csS) begin
      if (sclkRise && bitCnt < LAST_CNT)
        bitCnt <= bitCnt + CNT_W'(1);
      if (sclkFall && bitCnt == LAST_CNT)
        fullByte <= 1'b1;
    end
  end

  always_comb begin
    stb.shiftEn = ~csS & sclkRise & (bitCnt < LAST_CNT);
    stb.bitIn   = mosiS;
    stb.commit  = csRise & fullByte;
  end

  // R9
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_CNT);

  // R3
  full_needs_eight_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullByte |-> bitCnt == LAST_CNT);
endmodule

// File: rtl/pga_spi_dp.sv
module pga_spi_dp
  import pga_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  output logic              trimNeg,
  output logic [CODE_W-1:0] trimMag,
  output logic [CODE_W-1:0] gainCode,
  output logic [IDX_W-1:0]  gainIdx,
  output logic              shutdown,
  output logic              measure
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic selGain;

  assign selGain = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '0;
    else if (stb.shiftEn)
      shiftReg <= {stb.bitIn, shiftReg[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trimNeg  <= 1'b0;
      trimMag  <= '0;
      gainCode <= '0;
      gainIdx  <= UNITY_IDX;
      shutdown <= 1'b0;
      measure  <= 1'b0;
    end else if (stb.commit) begin
      shutdown <= shiftReg[7];
      measure  <= shiftReg[6];
      if (selGain) begin
        gainCode <= shiftReg[4:1];
        gainIdx  <= gainIndex(shiftReg[4:1]);
      end else begin
        trimNeg <= shiftReg[5];
        trimMag <= shiftReg[4:1];
      end
    end
  end

  // R3
  hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable({trimNeg, trimMag, gainCode, gainIdx, shutdown, measure}));

  // R4
  gain_kept_on_trim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !selGain) |=> $stable({gainCode, gainIdx}));

  // R5
  trim_kept_on_gain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && selGain) |=> $stable({trimNeg, trimMag}));

  // R8
  reserved_unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gainCode > CODE_W'(10)) |-> gainIdx == UNITY_IDX);
endmodule

// File: rtl/pga_ctrl_spi.sv
module pga_ctrl_spi
  import pga_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output logic       trimNeg,
  output logic [3:0] trimMag,
  output logic [3:0] gainCode,
  output logic [3:0] gainIdx,
  output logic       shutdown,
  output logic       measure
);
  spiStrobe_t stb;

  pga_spi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .stb(stb)
  );

  pga_spi_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .trimNeg(trimNeg), .trimMag(trimMag), .gainCode(gainCode),
    .gainIdx(gainIdx), .shutdown(shutdown), .measure(measure)
  );
endmodule

// File: tb/pga_ctrl_spi_test.sv
module pga_ctrl_spi_test;
  localparam int H = 8;  // system clocks per serial half period

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic trimNeg, shutdown, measure;
  logic [3:0] trimMag, gainCode, gainIdx;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  logic       eNeg = 0, eShd = 0, eMeas = 0;
  logic [3:0] eMag = 0, eCode = 0;

  always #10 clk = ~clk;  // 50 MHz

  pga_ctrl_spi uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .trimNeg(trimNeg), .trimMag(trimMag), .gainCode(gainCode),
    .gainIdx(gainIdx), .shutdown(shutdown), .measure(measure)
  );

  function automatic int expIdx(input int code);
    case (code)
      9: return 0;
      1: return 2; 2: return 3; 3: return 4; 4: return 5;
      5: return 6; 6: return 7; 7: return 8; 8: return 9;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nBits clocks; cutEarly raises select while the last clock is high
  task automatic sendFrame(input logic [7:0] b, input int nBits, input bit cutEarly);
    csN = 1'b0;
    waitN(H);
    for (int i = 0; i < nBits; i++) begin
      mosi = (i < 8) ? b[i] : 1'b1;
      waitN(H);
      sclk = 1'b1;
      waitN(H);
      if (cutEarly && i == nBits - 1) begin
        csN = 1'b1;
        waitN(H);
      end
      sclk = 1'b0;
    end
    waitN(H);
    csN = 1'b1;
    waitN(3 * H);
  endtask

  task automatic model(input logic [7:0] b);
    eShd  = b[7];
    eMeas = b[6];
    if (b[0]) eCode = b[4:1];
    else begin
      eNeg = b[5];
      eMag = b[4:1];
    end
  endtask

  task automatic checkAll(input string trimTag, input string gainTag, input string flagTag);
    check({trimTag, " trim sign"}, trimNeg, eNeg);
    check({trimTag, " trim mag"}, trimMag, eMag);
    check({gainTag, " gain code"}, gainCode, eCode);
    check({gainTag, " gain idx"}, gainIdx, expIdx(eCode));
    check({flagTag, " shutdown"}, shutdown, eShd);
    check({flagTag, " measure"}, measure, eMeas);
  endtask

  initial begin
    waitN(5);
    // R1: reset state
    check("R1 trim sign", trimNeg, 0);
    check("R1 trim mag", trimMag, 0);
    check("R1 gain code", gainCode, 0);
    check("R1 gain idx", gainIdx, 1);
    check("R1 shutdown", shutdown, 0);
    check("R1 measure", measure, 0);
    rstN = 1'b1;
    waitN(5);
    check("R1 after release", {trimNeg, trimMag, gainCode, shutdown, measure}, 0);

    // R2 R4 R5 R6 R7 R8 R10: full sweep of every byte
    for (int v = 0; v < 256; v++) begin
      bit prevShd;
      string tTag, gTag;
      prevShd = eShd;
      sendFrame(8'(v), 8, 1'b0);
      model(8'(v));
      tTag = v[0] ? "R5 kept" : "R2 R4";
      if (!v[0]) gTag = "R4 kept";
      else if (v[4:1] > 10) gTag = "R2 R8";
      else gTag = "R2 R5 R7";
      if (prevShd) begin
        tTag = {tTag, " R10"};
        gTag = {gTag, " R10"};
      end
      checkAll(tTag, gTag, "R6");
    end

    // known state: normal, gain code 3, trim +5
    sendFrame(8'b0000_0111, 8, 1'b0); model(8'b0000_0111);
    sendFrame(8'b0000_1010, 8, 1'b0); model(8'b0000_1010);
    checkAll("R4", "R7", "R6");

    // R3: seven-bit frame ignored
    sendFrame(8'b1101_1111, 7, 1'b0);
    checkAll("R3 short", "R3 short", "R3 short");
    // R3: select closed while eighth clock high
    sendFrame(8'b1101_1111, 8, 1'b1);
    checkAll("R3 early", "R3 early", "R3 early");

    // R9: ten clocks, extra bits are ones, first eight committed
    sendFrame(8'b0100_0000, 10, 1'b0); model(8'b0100_0000);
    checkAll("R9", "R9", "R9");
    sendFrame(8'b0000_0011, 10, 1'b0); model(8'b0000_0011);
    checkAll("R9", "R9", "R9");

    // R10: gain change while in shutdown
    sendFrame(8'b1000_1001, 8, 1'b0); model(8'b1000_1001);
    sendFrame(8'b1001_0001, 8, 1'b0); model(8'b1001_0001);
    checkAll("R10", "R10", "R10");
    check("R10 idx 157", gainIdx, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule